// File: doc/BRIEF.md
# Indexed codec control register port

This block is the host-facing control front end of a playback codec. A host sees four byte-wide direct addresses: an index register, a data window, a status byte and a programmed-I/O data byte. The index register selects one of the indirect 8-bit control registers, and the data window reads or writes that register. In basic mode the index is four bits wide and reaches 16 registers. Setting the extended-mode bit in the mode register widens it to five bits and 32 registers.

The block enforces the write policy of the bank. It applies reset defaults, masks the index width, and gates sample-format changes behind a mode-change-enable bit or a playback-only alternative. Reserved and read-only registers are write-protected, and the mode register has a single writable bit. The block also holds the interrupt flag and its clear paths. An autocalibration state machine with two states makes the error-status register report calibration in progress for a set number of reads. That machine has two states. `CAL_IDLE` moves to `CAL_ARMED` on the *load* transition, which is a rising mode-change-enable while calibration is enabled. `CAL_ARMED` stays in place on the *reload* transition (another qualifying rise) and on the *count* transition (a read of the error register that is not the last). It returns to `CAL_IDLE` on the *last-read* transition. Toward the playback datapath the block drives a playback enable, the current format byte and a one-cycle format-update strobe. The playback datapath raises the interrupt through a request input.

Top module: `codec_ctrl_port`

## Requirements
- R1: After reset, indirect registers 2, 3, 4, 5, 18 and 19 hold 0x88; 6 and 7 hold 0x80; 9 holds 0x08; 12 holds 0x8A; 25 and 26 hold 0xA0; all others hold 0x00. The irq, play_en and fmt_update outputs are 0.
- R2: Direct address 0 is the index register, and it resets to 0x40. Bit 7 is never stored and always reads 0. Bit 6 is the mode-change-enable (MCE) bit.
- R3: When bit 6 of register 12 is clear, the indirect address is index bits 3:0, so index 0x13 reaches register 3. When that bit is set, the indirect address is index bits 4:0.
- R4: With MCE set, a write to register 8 replaces all eight bits. fmt_value always shows register 8.
- R5: With MCE clear and bit 4 of register 24 set, a write to register 8 updates only bits 7:4. With both clear, the write is dropped. Every accepted write to register 8 pulses fmt_update for exactly the one cycle after the write edge.
- R6: Writes to registers 22, 27, 29 and 11 have no effect.
- R7: A write to register 9 stores the value with bit 5 forced to 0. play_en equals bit 0 of register 9.
- R8: In register 12 only bit 6 accepts writes; the other bits keep their reset value.
- R9: A write to the index register that raises MCE from 0 to 1 while bits 4:3 of register 9 are nonzero arms calibration for CAL_READS reads. Each data-window read of register 11 while armed returns bit 5 set and uses up one read. Once the reads are used up, bit 5 reads 0.
- R10: Any write to direct address 2 clears the INT flag, which is status bit 0 and drives irq. It also clears bits 6:4 of register 24.
- R11: A write to register 24 that takes bit 4 from 1 to 0 clears INT. A write that leaves bit 4 at 1 does not.
- R12: A cycle with pb_irq_set high sets INT and bit 4 of register 24. This set wins over a clear in the same cycle.
- R13: Direct address 3 always reads 0x00, and writes to it change no state.
- R14: Writes take effect at the clock edge where host_wr is high. host_rdata is combinational on the current state and host_addr. The calibration read count is used up on the edge where host_rd is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe; used for read side effects |
| host_addr | input | 2 | Direct address: 0 index, 1 data, 2 status, 3 PIO data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for host_addr |
| pb_irq_set | input | 1 | Interrupt request from the playback datapath |
| play_en | output | 1 | Playback enable (register 9 bit 0) |
| fmt_update | output | 1 | One-cycle strobe after an accepted format write |
| fmt_value | output | 8 | Current format register contents |
| irq | output | 1 | Interrupt line (INT flag) |

## Verification
The assertions assume that host_wr and host_rd are never high in the same cycle. They also assume that all inputs are held low while reset is active, because several properties compare against the cycle before. The bench drives every access through one task at a time, each lasting one cycle, and it keeps pb_irq_set low except in its dedicated pulse and priority steps. The rules about the format gate and calibration arming depend on the current MCE value, so the bench keeps MCE set while it sweeps registers. It clears MCE only on purpose, in the format-gating and calibration steps.

// File: rtl/codec_ctrl_pkg.sv
package codec_ctrl_pkg;

    localparam int NUM_REGS = 32;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int DATA_W   = 8;

    typedef enum logic [1:0] {
        HA_INDEX  = 2'd0,
        HA_DATA   = 2'd1,
        HA_STATUS = 2'd2,
        HA_PIO    = 2'd3
    } host_addr_e;

    typedef enum logic {
        CAL_IDLE  = 1'b0,
        CAL_ARMED = 1'b1
    } cal_state_e;

    // indirect register numbers whose behaviour differs
    localparam int REG_FMT     = 8;
    localparam int REG_CFG     = 9;
    localparam int REG_ERR     = 11;
    localparam int REG_MODE    = 12;
    localparam int REG_ALTSTAT = 24;

    localparam int MCE_BIT  = 6;
    localparam int EXT_BIT  = 6;
    localparam int PMCE_BIT = 4;
    localparam int PEN_BIT  = 0;
    localparam int CAL_FLAG = 5;

    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        case (idx)
            2, 3, 4, 5, 18, 19: reset_value = 8'h88;
            6, 7:               reset_value = 8'h80;
            9:                  reset_value = 8'h08;
            12:                 reset_value = 8'h8A;
            25, 26:             reset_value = 8'hA0;
            default:            reset_value = 8'h00;
        endcase
    endfunction

    function automatic bit is_locked(input int idx);
        case (idx)
            11, 22, 27, 29: is_locked = 1'b1;
            default:        is_locked = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ccp_index_reg.sv
module ccp_index_reg
    import codec_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ext_mode,
    output logic [DATA_W-1:0] idx_o,
    output logic              mce_o,
    output logic              mce_rise_o,
    output logic [IDX_W-1:0]  iaddr_o
);

    logic [DATA_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= 8'h40;
        end else if (wr_en) begin
            idx_q <= wdata & 8'h7F;
        end
    end

    assign idx_o      = idx_q;
    assign mce_o      = idx_q[MCE_BIT];
    assign mce_rise_o = wr_en && !idx_q[MCE_BIT] && wdata[MCE_BIT];
    assign iaddr_o    = ext_mode ? idx_q[IDX_W-1:0]
                                 : {1'b0, idx_q[IDX_W-2:0]};

endmodule

// File: rtl/ccp_calib_fsm.sv
module ccp_calib_fsm
    import codec_ctrl_pkg::*;
#(
    parameter int CAL_READS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic consume,
    output logic active_o
);

    localparam int CAL_W = $clog2(CAL_READS + 1);

    cal_state_e       state_q, state_d;
    logic [CAL_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CAL_IDLE: begin
                if (load) begin
                    state_d = CAL_ARMED;
                    cnt_d   = CAL_W'(CAL_READS);
                end
            end
            CAL_ARMED: begin
                if (load) begin
                    cnt_d = CAL_W'(CAL_READS);
                end else if (consume) begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == CAL_W'(1)) begin
                        state_d = CAL_IDLE;
                    end
                end
            end
        endcase
    end

    always_comb begin
        active_o = (state_q == CAL_ARMED);
    end

endmodule

// File: rtl/ccp_reg_bank.sv
module ccp_reg_bank
    import codec_ctrl_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                waddr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic                            mce,
    input  logic                            status_clr,
    input  logic                            irq_set,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o,
    output logic                            int_o,
    output logic                            fmt_stb_o
);

    logic [NUM_REGS-1:0][DATA_W-1:0] q, d;
    logic int_q, fmt_stb_q;
    logic pmce;

    assign pmce = q[REG_ALTSTAT][PMCE_BIT];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic hit;
        assign hit = wr_en && (waddr == IDX_W'(g));

        if (g == REG_FMT) begin : g_fmt
            assign d[g] = !hit ? q[g]
                        : mce  ? wdata
                        : pmce ? {wdata[7:4], q[g][3:0]}
                        :        q[g];
        end else if (g == REG_CFG) begin : g_cfg
            assign d[g] = hit ? (wdata & 8'hDF) : q[g];
        end else if (g == REG_MODE) begin : g_mode
            assign d[g] = hit ? {q[g][7], wdata[EXT_BIT], q[g][5:0]} : q[g];
        end else if (g == REG_ALTSTAT) begin : g_alt
            assign d[g] = ((hit ? wdata : q[g]) & (status_clr ? 8'h8F : 8'hFF))
                        | (irq_set ? 8'h10 : 8'h00);
        end else if (is_locked(g)) begin : g_lock
            assign d[g] = q[g];
        end else begin : g_plain
            assign d[g] = hit ? wdata : q[g];
        end
    end

    logic pmce_fall;
    assign pmce_fall = wr_en && (waddr == IDX_W'(REG_ALTSTAT))
                     && pmce && !wdata[PMCE_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                q[i] <= reset_value(i);
            end
            int_q     <= 1'b0;
            fmt_stb_q <= 1'b0;
        end else begin
            q         <= d;
            if (irq_set) begin
                int_q <= 1'b1;
            end else if (status_clr || pmce_fall) begin
                int_q <= 1'b0;
            end
            fmt_stb_q <= wr_en && (waddr == IDX_W'(REG_FMT)) && (mce || pmce);
        end
    end

    assign regs_o    = q;
    assign int_o     = int_q;
    assign fmt_stb_o = fmt_stb_q;

endmodule

// File: rtl/codec_ctrl_port.sv
module codec_ctrl_port
    import codec_ctrl_pkg::*;
#(
    parameter int CAL_READS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              pb_irq_set,
    output logic              play_en,
    output logic              fmt_update,
    output logic [DATA_W-1:0] fmt_value,
    output logic              irq
);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0] idx;
    logic [IDX_W-1:0]  iaddr;
    logic mce, mce_rise, int_flag, cal_active;
    logic idx_wr, data_wr, status_clr, cal_load, cal_consume;

    assign idx_wr      = host_wr && (host_addr == HA_INDEX);
    assign data_wr     = host_wr && (host_addr == HA_DATA);
    assign status_clr  = host_wr && (host_addr == HA_STATUS);
    assign cal_load    = mce_rise && (regs[REG_CFG][4:3] != 2'b00);
    assign cal_consume = host_rd && (host_addr == HA_DATA)
                       && (iaddr == IDX_W'(REG_ERR)) && cal_active;

    ccp_index_reg u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (idx_wr),
        .wdata      (host_wdata),
        .ext_mode   (regs[REG_MODE][EXT_BIT]),
        .idx_o      (idx),
        .mce_o      (mce),
        .mce_rise_o (mce_rise),
        .iaddr_o    (iaddr)
    );

    ccp_reg_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (data_wr),
        .waddr      (iaddr),
        .wdata      (host_wdata),
        .mce        (mce),
        .status_clr (status_clr),
        .irq_set    (pb_irq_set),
        .regs_o     (regs),
        .int_o      (int_flag),
        .fmt_stb_o  (fmt_update)
    );

    ccp_calib_fsm #(.CAL_READS(CAL_READS)) u_calib (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cal_load),
        .consume  (cal_consume),
        .active_o (cal_active)
    );

    always_comb begin
        unique case (host_addr)
            HA_INDEX:  host_rdata = idx;
            HA_DATA: begin
                host_rdata = regs[iaddr];
                if (iaddr == IDX_W'(REG_ERR) && cal_active) begin
                    host_rdata[CAL_FLAG] = 1'b1;
                end
            end
            HA_STATUS: host_rdata = {7'b0, int_flag};
            HA_PIO:    host_rdata = '0;
        endcase
    end

    assign play_en   = regs[REG_CFG][PEN_BIT];
    assign fmt_value = regs[REG_FMT];
    assign irq       = int_flag;

endmodule

// File: rtl/ccp_checker.sv
module ccp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_rd,
    input logic [1:0] host_addr,
    input logic [7:0] host_rdata,
    input logic       pb_irq_set,
    input logic       play_en,
    input logic       fmt_update,
    input logic [7:0] fmt_value,
    input logic       irq
);

    p_idx_msb_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == 2'd0) |-> !host_rdata[7]);

    p_fmt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(host_wr && host_addr == 2'd1) |-> $stable(fmt_value));

    p_strobe_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_update |-> $past(host_wr && host_addr == 2'd1));

    p_play_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(play_en) |-> $past(host_wr && host_addr == 2'd1));

    p_status_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd2 && !pb_irq_set) |=> !irq);

    p_irq_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pb_irq_set |=> irq);

    p_pio_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == 2'd3) |-> (host_rdata == 8'h00));

    p_no_rd_wr_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_rd));

endmodule

bind codec_ctrl_port ccp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .pb_irq_set (pb_irq_set),
    .play_en    (play_en),
    .fmt_update (fmt_update),
    .fmt_value  (fmt_value),
    .irq        (irq)
);

// File: tb/codec_ctrl_port_tb.sv
module codec_ctrl_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       pb_irq_set = 1'b0;
    logic       play_en, fmt_update, irq;
    logic [7:0] fmt_value;

    int checks = 0;
    int errors = 0;
    logic stb;
    logic [7:0] rv;
    logic [7:0] model [32];

    always #2 clk = ~clk;

    codec_ctrl_port #(.CAL_READS(2)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pb_irq_set (pb_irq_set),
        .play_en    (play_en),
        .fmt_update (fmt_update),
        .fmt_value  (fmt_value),
        .irq        (irq)
    );

    function automatic logic [7:0] exp_rst(input int i);
        if (i >= 2 && i <= 5)        return 8'h88;
        if (i == 18 || i == 19)      return 8'h88;
        if (i == 6 || i == 7)        return 8'h80;
        if (i == 9)                  return 8'h08;
        if (i == 12)                 return 8'h8A;
        if (i == 25 || i == 26)      return 8'hA0;
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic with_irq = 1'b0);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d; pb_irq_set = with_irq;
        @(negedge clk);
        host_wr = 1'b0; pb_irq_set = 1'b0;
        stb = fmt_update;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wi(input int idx, input logic [7:0] d);
        wr(2'd0, 8'h40 | 8'(idx));
        wr(2'd1, d);
    endtask

    task automatic ri(input int idx, output logic [7:0] v);
        wr(2'd0, 8'h40 | 8'(idx));
        rd(2'd1, v);
    endtask

    task automatic pulse_irq();
        @(negedge clk); pb_irq_set = 1'b1;
        @(negedge clk); pb_irq_set = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual 00 expected 01");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs, R2 index reset value
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 play_en", {7'b0, play_en}, 8'h00);
        chk("R1 fmt_update", {7'b0, fmt_update}, 8'h00);
        rd(2'd0, rv); chk("R2 index reset", rv, 8'h40);

        // R1 basic-mode sweep
        for (int i = 0; i < 16; i++) begin
            ri(i, rv); chk($sformatf("R1 reg %0d", i), rv, exp_rst(i));
        end

        // R3 aliasing in basic mode: index 0x13 reaches register 3
        wi(8'h13, 8'h55);
        ri(3, rv); chk("R3 alias to 3", rv, 8'h55);

        // R8 only bit 6 of register 12; enters extended mode
        wi(12, 8'hFF);
        ri(12, rv); chk("R8 mode reg", rv, 8'hCA);

        // R1/R3 extended sweep against model
        for (int i = 0; i < 32; i++) model[i] = exp_rst(i);
        model[3] = 8'h55; model[12] = 8'hCA;
        for (int i = 0; i < 32; i++) begin
            ri(i, rv); chk($sformatf("R3 ext reg %0d", i), rv, model[i]);
        end

        // R6 protected registers
        wi(22, 8'hFF); ri(22, rv); chk("R6 reg 22", rv, 8'h00);
        wi(27, 8'hFF); ri(27, rv); chk("R6 reg 27", rv, 8'h00);
        wi(29, 8'hFF); ri(29, rv); chk("R6 reg 29", rv, 8'h00);
        wi(11, 8'hFF); ri(11, rv); chk("R6 reg 11", rv, 8'h00);

        // R7 config register
        wi(9, 8'hFF); ri(9, rv); chk("R7 bit5 forced", rv, 8'hDF);
        chk("R7 play_en on", {7'b0, play_en}, 8'h01);
        wi(9, 8'h00);
        chk("R7 play_en off", {7'b0, play_en}, 8'h00);

        // R4 full format write with MCE
        wi(8, 8'h5A);
        chk("R5 strobe on MCE write", {7'b0, stb}, 8'h01);
        @(negedge clk);
        chk("R5 strobe one cycle", {7'b0, fmt_update}, 8'h00);
        chk("R4 fmt_value", fmt_value, 8'h5A);

        // R5 gated writes
        wr(2'd0, 8'h08); wr(2'd1, 8'hFF);
        chk("R5 dropped strobe", {7'b0, stb}, 8'h00);
        chk("R5 dropped value", fmt_value, 8'h5A);
        wr(2'd0, 8'h18); wr(2'd1, 8'h10);
        wr(2'd0, 8'h08); wr(2'd1, 8'hC3);
        chk("R5 partial strobe", {7'b0, stb}, 8'h01);
        chk("R5 partial value", fmt_value, 8'hCA);
        wr(2'd0, 8'h18); wr(2'd1, 8'h00);

        // R9 calibration: no arm when reg 9 bits 4:3 clear
        wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
        rd(2'd1, rv); chk("R9 not armed", rv, 8'h00);
        wr(2'd0, 8'h09); wr(2'd1, 8'h18);
        wr(2'd0, 8'h0B); wr(2'd0, 8'h4B);
        rd(2'd1, rv); chk("R9 read 1", rv, 8'h20);
        rd(2'd1, rv); chk("R9 read 2", rv, 8'h20);
        rd(2'd1, rv); chk("R9 exhausted", rv, 8'h00);

        // R12 set, R10 status clear
        wi(24, 8'h60);
        pulse_irq();
        chk("R12 irq set", {7'b0, irq}, 8'h01);
        rd(2'd2, rv); chk("R12 status bit", rv, 8'h01);
        ri(24, rv); chk("R12 reg24 bit4", rv, 8'h70);
        wr(2'd2, 8'h00);
        chk("R10 irq cleared", {7'b0, irq}, 8'h00);
        rd(2'd2, rv); chk("R10 status", rv, 8'h00);
        ri(24, rv); chk("R10 reg24 cleared", rv, 8'h00);

        // R11 reg 24 bit4 falling
        pulse_irq();
        wi(24, 8'h10);
        chk("R11 no fall keeps irq", {7'b0, irq}, 8'h01);
        wi(24, 8'h00);
        chk("R11 fall clears irq", {7'b0, irq}, 8'h00);

        // R12 priority over a same-cycle clear
        wr(2'd2, 8'h00, 1'b1);
        chk("R12 set wins", {7'b0, irq}, 8'h01);
        wr(2'd2, 8'h00);

        // R13 PIO data
        wr(2'd3, 8'hFF);
        rd(2'd3, rv); chk("R13 pio read", rv, 8'h00);
        chk("R13 irq untouched", {7'b0, irq}, 8'h00);
        ri(24, rv); chk("R13 reg24 untouched", rv, 8'h00);

        // R2 bit 7 dropped
        wr(2'd0, 8'hFF);
        rd(2'd0, rv); chk("R2 bit7 dropped", rv, 8'h7F);

        // R8/R3 back to basic mode: index 0x1C aliases to 12
        wi(12, 8'h00);
        ri(8'h1C, rv); chk("R3 basic alias 12", rv, 8'h8A);

        finish_run();
    end

endmodule